// File: doc/BRIEF.md
# Multi-Channel Interrupt Fan-Out Multiplexer

This block gathers a shared bank of level-sensitive, active-high interrupt request lines and delivers them to several independent output channels. Every request line goes to every channel. Each channel keeps its own enable mask, and the mask alone decides which lines can raise that channel's single interrupt output toward an upstream interrupt controller. Software uses one channel per destination, or per group of handlers, and moves a source between destinations by changing the masks.

Before they are used, the request lines pass through a two-flop synchronizer. A channel's pending word is the synchronized request vector ANDed with the channel's mask. The channel output is a registered OR of that word. Software reaches the masks and pending words through a word-wide register port with valid, write, address and data signals. Read data is registered and returned one cycle after the request. Each channel's registers sit at a fixed stride in the byte address space.

Top module: `irq_fanout_mux`

## Requirements
- R1: With the default parameters there are 8 channels and 32 request lines. The full request vector is presented to every channel, and a channel's pending word depends only on that channel's own mask.
- R2: Channel c has a read/write enable mask at byte address 0x10 + 0x40*c. Bit k of the mask admits request line k, and a read returns the last value written.
- R3: Channel c has a read-only pending word at byte address 0x20 + 0x40*c. It reads as (synchronized requests AND the channel's mask). A write to this address changes neither the mask nor the pending word.
- R4: `irq_o[c]` is the OR of channel c's pending bits, taken from a register. A request rising at the input (driven between edges) with its enable bit already set raises `irq_o` after the third rising clock edge, and not after the second.
- R5: A mask write takes effect on `irq_o` at the first rising edge after the edge that stores the mask.
- R6: While `rst_n` is low at a rising edge, every mask, every synchronizer stage, `irq_o` and the read data are cleared to zero.
- R7: Every address that is not a channel's mask or pending word is unmapped. This includes addresses at or beyond 0x40*8 and all other offsets inside a channel's window. A read of an unmapped address returns zero, and a write to one changes no register.
- R8: `reg_rdata_o` is updated only at the edge that completes a read request. It holds its value across idle cycles and writes.
- R9: Request lines are levels: a pending bit stays set for as long as its line stays high and enabled, and clears after the line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Asynchronous level-sensitive interrupt request lines, active high |
| reg_valid_i | input | 1 | Register access request for this cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte address of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered, valid the cycle after a read request |
| irq_o | output | 8 | One interrupt output per channel, active high |

## Verification
The hardest state to reach from the ports is one where the same source is live on several channels under different masks. In that state a single wrong decode, such as a write that reaches the wrong channel or a pending write that leaks into a mask, shows up only as a small difference between channels. The stimulus alternates random request vectors with random mask writes to random channels, including all-zero and all-one masks. After each step it reads back every channel's mask and pending word and compares them with a bench model. Directed cases then aim writes at pending addresses, at unused offsets inside a channel window and at addresses past the last channel, while other channels hold live pending bits. They also probe the exact cycle at which `irq_o` changes after a request edge and after a mask write.

// File: rtl/irq_fanout_pkg.sv
// Package: shared constants and types for the interrupt fan-out multiplexer.
// Assumes the channel stride is a power of two, so the in-window offset is a
// plain bit slice of the byte address.
package irq_fanout_pkg;

    // Byte distance between two channel register windows.
    localparam int unsigned CHAN_STRIDE = 32'h40;
    // Offset of the enable mask inside a channel window.
    localparam int unsigned MASK_OFS    = 32'h10;
    // Offset of the pending word inside a channel window.
    localparam int unsigned PEND_OFS    = 32'h20;

    // What a decoded register access targets.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irq_src_sync.sv
// Module: multi-stage synchronizer for asynchronous level inputs.
// Each bit goes through STAGES flops in series. Assumes the inputs are
// independent levels that need no cross-bit coherence, and that
// STAGES >= 2.
module irq_src_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage: capture the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Later stages: shift toward the output.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

    // R6: the synchronizer output is clear in the cycle after reset.
    p_sync_reset_r6: assert property (@(posedge clk) !rst_n |=> sync_o == '0)
        else $error("synchronizer not cleared by reset");

endmodule

// File: rtl/irq_reg_decode.sv
// Module: address decoder for the per-channel register windows.
// Splits the byte address into a channel index and an in-window offset.
// Produces one mask-write strobe per channel, plus a read selector and a
// channel index for the read mux. Assumes CHAN_STRIDE is a power of two.
// Every other address is unmapped.
module irq_reg_decode
    import irq_fanout_pkg::*;
#(
    parameter int unsigned NUM_CHAN = 8,
    parameter int unsigned ADDR_W   = 12,
    localparam int unsigned CH_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_CHAN-1:0] mask_wr_o,
    output reg_sel_e          rd_sel_o,
    output logic [CH_W-1:0]   rd_chan_o
);

    localparam int unsigned OFS_W = $clog2(CHAN_STRIDE);
    localparam int unsigned IDX_W = ADDR_W - OFS_W;
    localparam logic [IDX_W-1:0] CHAN_LIMIT = IDX_W'(NUM_CHAN);
    localparam logic [OFS_W-1:0] MASK_AT    = OFS_W'(MASK_OFS);
    localparam logic [OFS_W-1:0] PEND_AT    = OFS_W'(PEND_OFS);

    logic [IDX_W-1:0] chan_idx;
    logic [OFS_W-1:0] win_ofs;
    logic             chan_ok;
    reg_sel_e         sel;

    assign chan_idx = addr_i[ADDR_W-1:OFS_W];
    assign win_ofs  = addr_i[OFS_W-1:0];
    assign chan_ok  = (chan_idx < CHAN_LIMIT);

    // Classify the target register within an existing channel window.
    always_comb begin
        sel = SEL_NONE;
        if (chan_ok) begin
            if (win_ofs == MASK_AT)      sel = SEL_MASK;
            else if (win_ofs == PEND_AT) sel = SEL_PEND;
        end
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_strobe
        assign mask_wr_o[c] = valid_i && write_i && (sel == SEL_MASK) &&
                              (chan_idx == IDX_W'(c));
    end

    assign rd_sel_o  = sel;
    assign rd_chan_o = chan_idx[CH_W-1:0];

    // R7: at most one channel's mask is written per access.
    p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_wr_o))
        else $error("more than one mask strobe");

    // R3: a write to a pending address never strobes a mask.
    p_pend_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && write_i && win_ofs == PEND_AT) |-> (mask_wr_o == '0))
        else $error("pending-word write reached a mask");

endmodule

// File: rtl/irq_chan_slice.sv
// Module: one output channel.
// Holds the channel's enable mask, forms the masked pending word from the
// synchronized requests, and registers the OR of that word as the channel's
// interrupt output. Assumes the request vector is already synchronous to clk.
module irq_chan_slice #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    input  logic [NUM_SRC-1:0] src_sync_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] mask_q;
    logic               irq_q;

    // Enable mask: loaded by its strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= wdata_i;
    end

    assign pend_o = src_sync_i & mask_q;

    // Output register: OR of the masked pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend_o;
    end

    assign mask_o = mask_q;
    assign irq_o  = irq_q;

    // R6: mask and output are clear in the cycle after reset.
    p_mask_reset_r6: assert property (@(posedge clk) !rst_n |=> (mask_q == '0 && !irq_q))
        else $error("channel not cleared by reset");

    // R7: without this channel's strobe, the mask keeps its value.
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(mask_q))
        else $error("mask changed without a strobe");

    // R4: the output follows the previous cycle's pending word.
    p_irq_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (|$past(pend_o)))
        else $error("irq does not follow pending word");

endmodule

// File: rtl/irq_fanout_mux.sv
// Module: top level of the interrupt fan-out multiplexer.
// Synchronizes the shared request lines, presents them to every channel
// slice, decodes register accesses and returns registered read data.
// Assumes one access per cycle and a register width equal to the number
// of request lines.
module irq_fanout_mux
    import irq_fanout_pkg::*;
#(
    parameter int unsigned NUM_CHAN = 8,
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned SYNC_STG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                reg_valid_i,
    input  logic                reg_write_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [NUM_SRC-1:0]  reg_wdata_i,
    output logic [NUM_SRC-1:0]  reg_rdata_o,
    output logic [NUM_CHAN-1:0] irq_o
);

    localparam int unsigned CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

    logic [NUM_SRC-1:0]  src_sync;
    logic [NUM_CHAN-1:0] mask_wr;
    reg_sel_e            rd_sel;
    logic [CH_W-1:0]     rd_chan;
    logic [NUM_SRC-1:0]  mask_all [NUM_CHAN];
    logic [NUM_SRC-1:0]  pend_all [NUM_CHAN];
    logic [NUM_SRC-1:0]  rd_val;
    logic [NUM_SRC-1:0]  rdata_q;
    logic                rd_req;

    irq_src_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STG)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    irq_reg_decode #(
        .NUM_CHAN (NUM_CHAN),
        .ADDR_W   (ADDR_W)
    ) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (reg_valid_i),
        .write_i   (reg_write_i),
        .addr_i    (reg_addr_i),
        .mask_wr_o (mask_wr),
        .rd_sel_o  (rd_sel),
        .rd_chan_o (rd_chan)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        irq_chan_slice #(
            .NUM_SRC (NUM_SRC)
        ) slice_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_wr_i  (mask_wr[c]),
            .wdata_i    (reg_wdata_i),
            .src_sync_i (src_sync),
            .mask_o     (mask_all[c]),
            .pend_o     (pend_all[c]),
            .irq_o      (irq_o[c])
        );
    end

    // Read mux: pick the addressed channel's mask or pending word.
    always_comb begin
        unique case (rd_sel)
            SEL_MASK: rd_val = mask_all[rd_chan];
            SEL_PEND: rd_val = pend_all[rd_chan];
            default:  rd_val = '0;
        endcase
    end

    assign rd_req = reg_valid_i && !reg_write_i;

    // Read data register: loaded only when a read completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_val;
    end

    assign reg_rdata_o = rdata_q;

    // R8: read data holds when no read is requested.
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(reg_rdata_o))
        else $error("read data moved without a read");

    // R7: an unmapped read returns zero.
    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_sel == SEL_NONE) |=> (reg_rdata_o == '0))
        else $error("unmapped read returned nonzero");

endmodule

// File: tb/irq_fanout_mux_tb_top.sv
`timescale 1ns/1ps
module irq_fanout_mux_tb_top;

    localparam int NCH  = 8;
    localparam int NSRC = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            valid = 1'b0;
    logic            write = 1'b0;
    logic [11:0]     addr = '0;
    logic [NSRC-1:0] wdata = '0;
    logic [NSRC-1:0] rdata;
    logic [NCH-1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [NSRC-1:0] mask_m [NCH];

    always #2.5 clk = ~clk;

    irq_fanout_mux dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_valid_i (valid),
        .reg_write_i (write),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [11:0] mask_addr(int c);
        return 12'(32'h10 + 32'h40 * c);
    endfunction

    function automatic logic [11:0] pend_addr(int c);
        return 12'(32'h20 + 32'h40 * c);
    endfunction

    function automatic logic [NSRC-1:0] exp_pend(int c);
        return src & mask_m[c];
    endfunction

    function automatic logic [NCH-1:0] exp_irq();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = |exp_pend(c);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [NSRC-1:0] d);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [NSRC-1:0] d);
        @(negedge clk);
        valid = 1'b1; write = 1'b0; addr = a;
        @(negedge clk);
        valid = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Full sweep: every mask, pending word and output against the model.
    task automatic sweep();
        logic [NSRC-1:0] d;
        for (int c = 0; c < NCH; c++) begin
            reg_read(mask_addr(c), d);
            check(d == mask_m[c], "R2 mask readback", d, mask_m[c]);
            reg_read(pend_addr(c), d);
            check(d == exp_pend(c), "R1 R3 pending word", d, exp_pend(c));
        end
        check(irq == exp_irq(), "R4 channel outputs", 32'(irq), 32'(exp_irq()));
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NSRC-1:0] d;
        logic [NSRC-1:0] held;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) mask_m[c] = '0;

        // R6: reset state
        repeat (3) @(negedge clk);
        check(irq == '0, "R6 irq after reset", 32'(irq), 0);
        check(rdata == '0, "R6 rdata after reset", rdata, 0);
        rst_n = 1'b1;
        src = '1;
        settle();
        sweep();
        check(irq == '0, "R6 masks cleared, no output", 32'(irq), 0);

        // R4: latency from request edge to output
        src = '0;
        settle();
        reg_write(mask_addr(2), 32'h0000_0020);
        mask_m[2] = 32'h0000_0020;
        settle();
        @(negedge clk) src[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(irq[2] == 1'b0, "R4 not after second edge", 32'(irq[2]), 0);
        @(negedge clk);
        check(irq[2] == 1'b1, "R4 set after third edge", 32'(irq[2]), 1);

        // R5: mask write timing on the output
        reg_write(mask_addr(3), 32'h0000_0020);
        mask_m[3] = 32'h0000_0020;
        check(irq[3] == 1'b0, "R5 not yet at write edge", 32'(irq[3]), 0);
        @(negedge clk);
        check(irq[3] == 1'b1, "R5 set one edge after write", 32'(irq[3]), 1);
        reg_write(mask_addr(2), '0);
        mask_m[2] = '0;
        check(irq[2] == 1'b1, "R5 still set at write edge", 32'(irq[2]), 1);
        @(negedge clk);
        check(irq[2] == 1'b0, "R5 cleared one edge after write", 32'(irq[2]), 0);

        // R9: level behaviour, held high then released
        repeat (10) @(negedge clk);
        reg_read(pend_addr(3), d);
        check(d == 32'h20, "R9 pending held while high", d, 32'h20);
        check(irq[3] == 1'b1, "R9 output held while high", 32'(irq[3]), 1);
        src[5] = 1'b0;
        settle();
        reg_read(pend_addr(3), d);
        check(d == 32'h0, "R9 pending clears after fall", d, 0);
        check(irq[3] == 1'b0, "R9 output clears after fall", 32'(irq[3]), 0);

        // R3: writes to pending addresses are ignored
        src = 32'hA5A5_0F0F;
        reg_write(mask_addr(4), 32'hFFFF_0000);
        mask_m[4] = 32'hFFFF_0000;
        settle();
        reg_write(pend_addr(4), 32'h0000_0000);
        reg_write(pend_addr(5), 32'hFFFF_FFFF);
        settle();
        reg_read(mask_addr(4), d);
        check(d == 32'hFFFF_0000, "R3 mask kept after pending write", d, 32'hFFFF_0000);
        reg_read(mask_addr(5), d);
        check(d == 32'h0, "R3 other mask kept after pending write", d, 0);
        reg_read(pend_addr(4), d);
        check(d == 32'hA5A5_0000, "R3 pending unchanged by write", d, 32'hA5A5_0000);
        check(irq == exp_irq(), "R3 outputs unchanged", 32'(irq), 32'(exp_irq()));

        // R7: unmapped writes ignored, unmapped reads zero
        reg_write(12'h014, '1);
        reg_write(12'h030, '1);
        reg_write(12'h000, '1);
        reg_write(12'h210, '1);
        reg_write(12'h3D0, '1);
        settle();
        sweep();
        reg_read(mask_addr(4), d);
        reg_read(12'h210, d);
        check(d == '0, "R7 read past last channel is zero", d, 0);
        reg_read(mask_addr(4), d);
        reg_read(12'h014, d);
        check(d == '0, "R7 read of unused offset is zero", d, 0);

        // R8: read data holds across idle cycles and writes
        reg_read(mask_addr(4), d);
        held = rdata;
        repeat (5) @(negedge clk);
        check(rdata == held, "R8 rdata held while idle", rdata, held);
        reg_write(mask_addr(6), 32'h1234_5678);
        mask_m[6] = 32'h1234_5678;
        check(rdata == held, "R8 rdata held across write", rdata, held);

        // R1: all-ones request vector, distinct masks per channel
        src = '1;
        for (int c = 0; c < NCH; c++) begin
            mask_m[c] = 32'h1 << (c * 4);
            reg_write(mask_addr(c), mask_m[c]);
        end
        settle();
        sweep();

        // Random mix of request changes and mask writes
        for (int it = 0; it < 60; it++) begin
            int sel;
            int ch;
            sel = int'($urandom_range(0, 3));
            ch  = int'($urandom_range(0, NCH - 1));
            if (sel == 0) begin
                src = $urandom();
            end else begin
                logic [NSRC-1:0] v;
                case (int'($urandom_range(0, 5)))
                    0:       v = '0;
                    1:       v = '1;
                    default: v = $urandom();
                endcase
                reg_write(mask_addr(ch), v);
                mask_m[ch] = v;
            end
            if (it % 3 == 0) src = $urandom();
            settle();
            sweep();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule